// File: doc/BRIEF.md
# Switch Address Table Operation Engine

This block runs software-issued commands against a small table of learned station addresses inside an Ethernet switch. Every table entry carries a 48-bit MAC address, an 8-bit database number, a 4-bit entry state, a trunk flag and a per-port membership vector. A state of zero marks a free slot. State 0xF marks a static entry.

Software works through six 16-bit registers. It fills in the MAC, data and database fields, then writes an opcode with the busy bit set. The engine walks the table one slot per clock. Busy drops when the command is done, and software polls busy before it issues the next command. The commands are:

- load or purge of one entry;
- get-next, which steps through one database in ascending MAC order;
- four flush/move variants.

For a flush/move, the state written to the data register picks the action: zero flushes, 0xF moves a port. For a move, the port vector holds the source port and the destination port side by side.

Top module: `atu_engine`

## Requirements
- R1: Writing register 1 with bit 15 set starts the command whose opcode is in bits [14:12]. The opcodes are 3 = load/purge, 4 = get-next, 1 = flush/move every entry in every database, 2 = non-static entries in every database, 5 = every entry in the selected database, 6 = non-static entries in the selected database. Register 1 bit 15 then reads 1 and returns to 0 within DEPTH+1 cycles. Opcodes 0 and 7 change nothing.
- R2: Register 2 holds the state in bits [3:0], the port vector in bits [4+NPORT-1:4] and the trunk flag in bit 15. Registers 3, 4 and 5 hold MAC bytes 0-1, 2-3 and 4-5, with the lower-numbered byte in bits [15:8]. Any register reads back one cycle after its address is presented.
- R3: The database number is {register 0 bits [15:12], register 1 bits [3:0]}. Entries of other databases are never matched by load, purge, get-next or the per-database flushes.
- R4: Load with a nonzero state writes the MAC, database, state, trunk and vector. It replaces an existing entry with the same MAC and database, or otherwise fills a free slot.
- R5: Load with state 0 removes the entry that matches both MAC and database. It does nothing if no entry matches.
- R6: Get-next loads the registers with the valid entry of the selected database whose MAC is the smallest one above the MAC in the registers. An all-ones MAC in the registers starts from the lowest entry. If no such entry exists, the state reads 0 and the MAC reads all ones. Get-next never alters the table.
- R7: Flush/move with state 0 removes every entry in its scope. The non-static variants leave state-0xF entries alone. A state other than 0 or 0xF changes nothing.
- R8: Flush/move with state 0xF takes the source port from vector bits [2:0] and the destination port from bits [5:3]. In every matched entry that contains the source port, the source bit is replaced by the destination bit. A destination of 7 only clears the source bit. An entry whose vector becomes empty is removed.
- R9: A load that has no match and finds no free slot writes nothing and sets register 0 bit 0. That bit stays set until software writes register 0 with bit 0 = 1 while the engine is idle.
- R10: While busy, writes to any register are ignored.
- R11: After reset every register reads 0 and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 control, 1 command, 2 data, 3..5 MAC) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for reg_addr |

## Verification
The bench goes after the table filling up. A design that overwrote a slot, or forgot to raise the sticky flag, would show an extra or missing entry in a walk, or a wrong control bit 0.

Moves are tested into destination 7, into an empty vector, and against static entries. Missing any of these would leave stale ports or phantom entries, or would move static addresses.

Databases that share their low four bits are mixed in the table, so a design that ignored the high database bits would return foreign entries from get-next. Register writes are also issued while a command is running; a design that accepted them would corrupt the command or the read-back values.

// File: rtl/atu_pkg.sv
package atu_pkg;
  localparam int MAC_W = 48;
  localparam int FID_W = 8;
  localparam int ST_W  = 4;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_CMD  = 3'd1;
  localparam logic [2:0] RA_DATA = 3'd2;
  localparam logic [2:0] RA_MAC0 = 3'd3;
  localparam logic [2:0] RA_MAC1 = 3'd4;
  localparam logic [2:0] RA_MAC2 = 3'd5;

  localparam logic [2:0] OPC_FM_ALL_ANY = 3'd1;
  localparam logic [2:0] OPC_FM_DYN_ANY = 3'd2;
  localparam logic [2:0] OPC_LOAD       = 3'd3;
  localparam logic [2:0] OPC_NEXT       = 3'd4;
  localparam logic [2:0] OPC_FM_ALL_ONE = 3'd5;
  localparam logic [2:0] OPC_FM_DYN_ONE = 3'd6;

  localparam logic [ST_W-1:0] ST_FREE   = 4'h0;
  localparam logic [ST_W-1:0] ST_STATIC = 4'hF;
endpackage

// File: rtl/atu_regs.sv
module atu_regs import atu_pkg::*; #(
  parameter int NPORT = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [15:0]      wdata,
  output logic [15:0]      rdata,
  input  logic             done_i,
  input  logic             upd_en_i,
  input  logic [MAC_W-1:0] upd_mac_i,
  input  logic [ST_W-1:0]  upd_st_i,
  input  logic             upd_trk_i,
  input  logic [NPORT-1:0] upd_pv_i,
  input  logic             full_set_i,
  output logic             start_o,
  output logic [2:0]       op_o,
  output logic [FID_W-1:0] fid_o,
  output logic [MAC_W-1:0] mac_o,
  output logic [ST_W-1:0]  st_o,
  output logic             trk_o,
  output logic [NPORT-1:0] pv_o
);
  localparam int CNT_W = $clog2(DEPTH + 3) + 1;

  logic [MAC_W-1:0] mac_q;
  logic [ST_W-1:0]  st_q;
  logic             trk_q;
  logic [NPORT-1:0] pv_q;
  logic [3:0]       fid_hi_q, fid_lo_q;
  logic [2:0]       op_q;
  logic             busy_q, full_q;
  logic [15:0]      rdata_q, rd_mux, data_word;
  logic             wr_ok;

  assign wr_ok   = we && !busy_q;
  assign start_o = wr_ok && (addr == RA_CMD) && wdata[15];

  always_ff @(posedge clk) begin
    if (rst) begin
      mac_q <= '0; st_q <= '0; trk_q <= 1'b0; pv_q <= '0;
      fid_hi_q <= '0; fid_lo_q <= '0; op_q <= '0;
      busy_q <= 1'b0; full_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        case (addr)
          RA_CTRL: begin
            fid_hi_q <= wdata[15:12];
            if (wdata[0]) full_q <= 1'b0;
          end
          RA_CMD: begin
            busy_q   <= wdata[15];
            op_q     <= wdata[14:12];
            fid_lo_q <= wdata[3:0];
          end
          RA_DATA: begin
            st_q  <= wdata[3:0];
            pv_q  <= wdata[4 +: NPORT];
            trk_q <= wdata[15];
          end
          RA_MAC0: mac_q[47:32] <= wdata;
          RA_MAC1: mac_q[31:16] <= wdata;
          RA_MAC2: mac_q[15:0]  <= wdata;
          default: ;
        endcase
      end
      if (full_set_i) full_q <= 1'b1;
      if (upd_en_i) begin
        mac_q <= upd_mac_i; st_q <= upd_st_i;
        trk_q <= upd_trk_i; pv_q <= upd_pv_i;
      end
      if (done_i) busy_q <= 1'b0;
    end
  end

  always_comb begin
    data_word = '0;
    data_word[3:0] = st_q;
    data_word[4 +: NPORT] = pv_q;
    data_word[15] = trk_q;
    case (addr)
      RA_CTRL: rd_mux = {fid_hi_q, 11'd0, full_q};
      RA_CMD:  rd_mux = {busy_q, op_q, 8'd0, fid_lo_q};
      RA_DATA: rd_mux = data_word;
      RA_MAC0: rd_mux = mac_q[47:32];
      RA_MAC1: rd_mux = mac_q[31:16];
      RA_MAC2: rd_mux = mac_q[15:0];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
  assign op_o  = op_q;
  assign fid_o = {fid_hi_q, fid_lo_q};
  assign mac_o = mac_q;
  assign st_o  = st_q;
  assign trk_o = trk_q;
  assign pv_o  = pv_q;

  logic [CNT_W-1:0] busy_cnt;
  always_ff @(posedge clk) begin
    if (rst)         busy_cnt <= '0;
    else if (busy_q) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  a_r1_busy_bounded: assert property (@(posedge clk) disable iff (rst)
    busy_cnt <= CNT_W'(DEPTH + 1));
  a_r1_busy_held: assert property (@(posedge clk) disable iff (rst)
    busy_q && !done_i |=> busy_q);
  a_r10_mac_locked: assert property (@(posedge clk) disable iff (rst)
    busy_q && !upd_en_i |=> $stable(mac_q));
  a_r10_fid_locked: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(fid_hi_q) && $stable(fid_lo_q));
endmodule

// File: rtl/atu_table.sv
module atu_table import atu_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int NPORT = 8,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IW-1:0]    rd_idx,
  output logic [MAC_W-1:0] rd_mac,
  output logic [FID_W-1:0] rd_fid,
  output logic [ST_W-1:0]  rd_st,
  output logic             rd_trk,
  output logic [NPORT-1:0] rd_pv,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic [MAC_W-1:0] wr_mac,
  input  logic [FID_W-1:0] wr_fid,
  input  logic [ST_W-1:0]  wr_st,
  input  logic             wr_trk,
  input  logic [NPORT-1:0] wr_pv
);
  localparam int PAY_W = MAC_W + FID_W + 1 + NPORT;

  logic [PAY_W-1:0] pay_mem [DEPTH];
  logic [ST_W-1:0]  st_mem  [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) pay_mem[wr_idx] <= {wr_mac, wr_fid, wr_trk, wr_pv};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) st_mem[i] <= ST_FREE;
    end else if (wr_en) begin
      st_mem[wr_idx] <= wr_st;
    end
  end

  assign {rd_mac, rd_fid, rd_trk, rd_pv} = pay_mem[rd_idx];
  assign rd_st = st_mem[rd_idx];
endmodule

// File: rtl/atu_ctrl.sv
module atu_ctrl import atu_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int NPORT = 8,
  parameter int PN_W  = 3,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [2:0]       op_i,
  input  logic [FID_W-1:0] fid_i,
  input  logic [MAC_W-1:0] mac_i,
  input  logic [ST_W-1:0]  st_i,
  input  logic             trk_i,
  input  logic [NPORT-1:0] pv_i,
  output logic [IW-1:0]    rd_idx,
  input  logic [MAC_W-1:0] rd_mac,
  input  logic [FID_W-1:0] rd_fid,
  input  logic [ST_W-1:0]  rd_st,
  input  logic             rd_trk,
  input  logic [NPORT-1:0] rd_pv,
  output logic             tbl_we,
  output logic [IW-1:0]    tbl_idx,
  output logic [MAC_W-1:0] tbl_mac,
  output logic [FID_W-1:0] tbl_fid,
  output logic [ST_W-1:0]  tbl_st,
  output logic             tbl_trk,
  output logic [NPORT-1:0] tbl_pv,
  output logic             done_o,
  output logic             upd_en_o,
  output logic [MAC_W-1:0] upd_mac_o,
  output logic [ST_W-1:0]  upd_st_o,
  output logic             upd_trk_o,
  output logic [NPORT-1:0] upd_pv_o,
  output logic             full_set_o
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_FIN} fsm_e;

  fsm_e             fsm;
  logic [IW-1:0]    idx;
  logic             hit_ok, free_ok, best_ok;
  logic [IW-1:0]    hit_idx, free_idx;
  logic [MAC_W-1:0] best_mac;
  logic [ST_W-1:0]  best_st;
  logic             best_trk;
  logic [NPORT-1:0] best_pv;

  logic valid_e, fid_eq, mac_ones, is_fm, fm_any_db, fm_all_ent, fm_match;
  logic is_load, is_next, next_cand;
  logic [PN_W-1:0]  src_port, dst_port;
  logic [NPORT-1:0] src_bit, dst_bit, moved_pv;

  assign valid_e    = (rd_st != ST_FREE);
  assign fid_eq     = (rd_fid == fid_i);
  assign mac_ones   = &mac_i;
  assign is_load    = (op_i == OPC_LOAD);
  assign is_next    = (op_i == OPC_NEXT);
  assign is_fm      = (op_i == OPC_FM_ALL_ANY) || (op_i == OPC_FM_DYN_ANY) ||
                      (op_i == OPC_FM_ALL_ONE) || (op_i == OPC_FM_DYN_ONE);
  assign fm_any_db  = (op_i == OPC_FM_ALL_ANY) || (op_i == OPC_FM_DYN_ANY);
  assign fm_all_ent = (op_i == OPC_FM_ALL_ANY) || (op_i == OPC_FM_ALL_ONE);
  assign fm_match   = valid_e && (fm_any_db || fid_eq) &&
                      (fm_all_ent || (rd_st != ST_STATIC));
  assign next_cand  = valid_e && fid_eq && (mac_ones || (rd_mac > mac_i)) &&
                      (!best_ok || (rd_mac < best_mac));

  assign src_port = pv_i[PN_W-1:0];
  assign dst_port = pv_i[2*PN_W-1:PN_W];
  assign src_bit  = NPORT'(1) << src_port;
  assign dst_bit  = (&dst_port) ? '0 : (NPORT'(1) << dst_port);
  assign moved_pv = (rd_pv & ~src_bit) | dst_bit;

  assign rd_idx = idx;

  always_comb begin
    tbl_we = 1'b0; tbl_idx = idx;
    tbl_mac = rd_mac; tbl_fid = rd_fid; tbl_st = rd_st;
    tbl_trk = rd_trk; tbl_pv = rd_pv;
    done_o = 1'b0; upd_en_o = 1'b0; full_set_o = 1'b0;
    upd_mac_o = best_mac; upd_st_o = best_st;
    upd_trk_o = best_trk; upd_pv_o = best_pv;
    case (fsm)
      S_SCAN: begin
        if (is_fm && fm_match) begin
          if (st_i == ST_FREE) begin
            tbl_we = 1'b1; tbl_st = ST_FREE;
          end else if (st_i == ST_STATIC && |(rd_pv & src_bit)) begin
            tbl_we = 1'b1; tbl_pv = moved_pv;
            tbl_st = (moved_pv == '0) ? ST_FREE : rd_st;
          end
        end
      end
      S_FIN: begin
        done_o = 1'b1;
        if (is_load) begin
          tbl_mac = mac_i; tbl_fid = fid_i; tbl_st = st_i;
          tbl_trk = trk_i; tbl_pv = pv_i;
          if (st_i != ST_FREE) begin
            if (hit_ok)       begin tbl_we = 1'b1; tbl_idx = hit_idx;  end
            else if (free_ok) begin tbl_we = 1'b1; tbl_idx = free_idx; end
            else              full_set_o = 1'b1;
          end else if (hit_ok) begin
            tbl_we = 1'b1; tbl_idx = hit_idx;
          end
        end
        if (is_next) begin
          upd_en_o = 1'b1;
          if (!best_ok) begin
            upd_mac_o = '1; upd_st_o = ST_FREE;
            upd_trk_o = 1'b0; upd_pv_o = '0;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm <= S_IDLE; idx <= '0;
      hit_ok <= 1'b0; free_ok <= 1'b0; best_ok <= 1'b0;
      hit_idx <= '0; free_idx <= '0;
      best_mac <= '0; best_st <= '0; best_trk <= 1'b0; best_pv <= '0;
    end else begin
      case (fsm)
        S_IDLE: if (start_i) begin
          fsm <= S_SCAN; idx <= '0;
          hit_ok <= 1'b0; free_ok <= 1'b0; best_ok <= 1'b0;
        end
        S_SCAN: begin
          if (valid_e && fid_eq && rd_mac == mac_i) begin
            hit_ok <= 1'b1; hit_idx <= idx;
          end
          if (!valid_e && !free_ok) begin
            free_ok <= 1'b1; free_idx <= idx;
          end
          if (next_cand) begin
            best_ok <= 1'b1; best_mac <= rd_mac; best_st <= rd_st;
            best_trk <= rd_trk; best_pv <= rd_pv;
          end
          if (idx == IW'(DEPTH - 1)) fsm <= S_FIN;
          else                       idx <= idx + 1'b1;
        end
        default: fsm <= S_IDLE;
      endcase
    end
  end

  a_r6_next_above: assert property (@(posedge clk) disable iff (rst)
    upd_en_o && upd_st_o != ST_FREE && !mac_ones |-> upd_mac_o > mac_i);
  a_r6_next_readonly: assert property (@(posedge clk) disable iff (rst)
    fsm != S_IDLE && is_next |-> !tbl_we);
  a_r5_purge_frees: assert property (@(posedge clk) disable iff (rst)
    tbl_we && is_load && st_i == ST_FREE |-> tbl_st == ST_FREE);
  a_r8_source_cleared: assert property (@(posedge clk) disable iff (rst)
    tbl_we && is_fm && st_i == ST_STATIC && src_port != dst_port
    |-> (tbl_pv & src_bit) == '0);
  a_r9_full_no_write: assert property (@(posedge clk) disable iff (rst)
    full_set_o |-> !tbl_we && is_load);
endmodule

// File: rtl/atu_engine.sv
module atu_engine import atu_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int NPORT = 8,
  parameter int PN_W  = 3,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata
);
  logic             start, done, upd_en, full_set;
  logic [2:0]       op;
  logic [FID_W-1:0] fid;
  logic [MAC_W-1:0] mac, upd_mac;
  logic [ST_W-1:0]  st, upd_st;
  logic             trk, upd_trk;
  logic [NPORT-1:0] pv, upd_pv;

  logic [IW-1:0]    rd_idx, wr_idx;
  logic [MAC_W-1:0] rd_mac, wr_mac;
  logic [FID_W-1:0] rd_fid, wr_fid;
  logic [ST_W-1:0]  rd_st, wr_st;
  logic             rd_trk, wr_trk, wr_en;
  logic [NPORT-1:0] rd_pv, wr_pv;

  atu_regs #(.NPORT(NPORT), .DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .done_i(done), .upd_en_i(upd_en), .upd_mac_i(upd_mac),
    .upd_st_i(upd_st), .upd_trk_i(upd_trk), .upd_pv_i(upd_pv),
    .full_set_i(full_set), .start_o(start), .op_o(op), .fid_o(fid),
    .mac_o(mac), .st_o(st), .trk_o(trk), .pv_o(pv)
  );

  atu_table #(.DEPTH(DEPTH), .NPORT(NPORT)) u_table (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_mac(rd_mac), .rd_fid(rd_fid),
    .rd_st(rd_st), .rd_trk(rd_trk), .rd_pv(rd_pv), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_mac(wr_mac), .wr_fid(wr_fid), .wr_st(wr_st),
    .wr_trk(wr_trk), .wr_pv(wr_pv)
  );

  atu_ctrl #(.DEPTH(DEPTH), .NPORT(NPORT), .PN_W(PN_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start), .op_i(op), .fid_i(fid),
    .mac_i(mac), .st_i(st), .trk_i(trk), .pv_i(pv), .rd_idx(rd_idx),
    .rd_mac(rd_mac), .rd_fid(rd_fid), .rd_st(rd_st), .rd_trk(rd_trk),
    .rd_pv(rd_pv), .tbl_we(wr_en), .tbl_idx(wr_idx), .tbl_mac(wr_mac),
    .tbl_fid(wr_fid), .tbl_st(wr_st), .tbl_trk(wr_trk), .tbl_pv(wr_pv),
    .done_o(done), .upd_en_o(upd_en), .upd_mac_o(upd_mac),
    .upd_st_o(upd_st), .upd_trk_o(upd_trk), .upd_pv_o(upd_pv),
    .full_set_o(full_set)
  );
endmodule

// File: tb/test_atu_engine.sv
module test_atu_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam logic [47:0] ONES = 48'hFFFF_FFFF_FFFF;

  logic clk = 1'b0, rst = 1'b1, reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  logic [47:0] m_mac [DEPTH];
  logic [7:0]  m_fid [DEPTH];
  logic [3:0]  m_st  [DEPTH];
  logic        m_trk [DEPTH];
  logic [7:0]  m_pv  [DEPTH];
  bit m_full = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atu_engine i_atu_engine (.clk(clk), .rst(rst), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] v);
    @(negedge clk); reg_we = 1'b0; reg_addr = a;
    @(negedge clk); v = reg_rdata;
  endtask

  task automatic rd_mac(output logic [47:0] m);
    logic [15:0] a, b, c;
    rd(3'd3, a); rd(3'd4, b); rd(3'd5, c);
    m = {a, b, c};
  endtask

  task automatic set_mac(logic [47:0] m);
    wr(3'd3, m[47:32]); wr(3'd4, m[31:16]); wr(3'd5, m[15:0]);
  endtask

  function automatic logic [15:0] dword(logic [3:0] s, logic t, logic [7:0] p);
    return {t, 3'b000, p, s};
  endfunction

  task automatic wait_idle();
    logic [15:0] v;
    for (int k = 0; k < 40; k++) begin
      rd(3'd1, v);
      if (!v[15]) return;
    end
    chk(0, "R1 busy never cleared", 1, 0);
  endtask

  task automatic do_op(logic [2:0] op, logic [7:0] fid);
    wr(3'd0, {fid[7:4], 12'd0});
    wr(3'd1, {1'b1, op, 8'd0, fid[3:0]});
    wait_idle();
  endtask

  // reference model
  function automatic int m_find(logic [47:0] mac, logic [7:0] fid);
    for (int i = 0; i < DEPTH; i++)
      if (m_st[i] != 0 && m_mac[i] == mac && m_fid[i] == fid) return i;
    return -1;
  endfunction

  task automatic m_load(logic [47:0] mac, logic [7:0] fid, logic [3:0] s,
                        logic t, logic [7:0] p);
    int h, f;
    h = m_find(mac, fid);
    f = -1;
    for (int i = DEPTH-1; i >= 0; i--) if (m_st[i] == 0) f = i;
    if (s == 0) begin
      if (h >= 0) m_st[h] = 0;
    end else begin
      if (h < 0) h = f;
      if (h < 0) m_full = 1;
      else begin
        m_mac[h] = mac; m_fid[h] = fid; m_st[h] = s; m_trk[h] = t; m_pv[h] = p;
      end
    end
  endtask

  task automatic m_fm(logic [2:0] op, logic [7:0] fid, logic [3:0] s, logic [7:0] p);
    bit anydb, allent;
    logic [7:0] sb, db, np;
    anydb  = (op == 1 || op == 2);
    allent = (op == 1 || op == 5);
    sb = 8'd1 << p[2:0];
    db = (p[5:3] == 3'd7) ? 8'd0 : (8'd1 << p[5:3]);
    for (int i = 0; i < DEPTH; i++) begin
      if (m_st[i] != 0 && (anydb || m_fid[i] == fid) && (allent || m_st[i] != 4'hF)) begin
        if (s == 0) m_st[i] = 0;
        else if (s == 4'hF && (m_pv[i] & sb) != 0) begin
          np = (m_pv[i] & ~sb) | db;
          m_pv[i] = np;
          if (np == 0) m_st[i] = 0;
        end
      end
    end
  endtask

  function automatic int m_next(logic [7:0] fid, logic [47:0] cur);
    int b;
    b = -1;
    for (int i = 0; i < DEPTH; i++)
      if (m_st[i] != 0 && m_fid[i] == fid && (cur == ONES || m_mac[i] > cur) &&
          (b < 0 || m_mac[i] < m_mac[b])) b = i;
    return b;
  endfunction

  task automatic hw_load(logic [47:0] mac, logic [7:0] fid, logic [3:0] s,
                         logic t, logic [7:0] p);
    set_mac(mac);
    wr(3'd2, dword(s, t, p));
    do_op(3'd3, fid);
    m_load(mac, fid, s, t, p);
  endtask

  task automatic hw_fm(logic [2:0] op, logic [7:0] fid, logic [3:0] s, logic [7:0] p);
    wr(3'd2, dword(s, 1'b0, p));
    do_op(op, fid);
    m_fm(op, fid, s, p);
  endtask

  // R6 / R3: walk one database through get-next and compare with the model
  task automatic walk(logic [7:0] fid);
    logic [47:0] cur, m;
    logic [15:0] d;
    int e;
    cur = ONES;
    set_mac(ONES);
    wr(3'd2, 16'd0);
    for (int k = 0; k <= DEPTH; k++) begin
      e = m_next(fid, cur);
      do_op(3'd4, fid);
      rd(3'd2, d);
      rd_mac(m);
      if (e < 0) begin
        chk(d[3:0] == 0, "R6 end state", 64'(d), 0);
        chk(m == ONES, "R6 end mac", 64'(m), 64'(ONES));
        break;
      end
      chk(d == dword(m_st[e], m_trk[e], m_pv[e]), "R6 next data", 64'(d),
          64'(dword(m_st[e], m_trk[e], m_pv[e])));
      chk(m == m_mac[e], "R6 next mac", 64'(m), 64'(m_mac[e]));
      cur = m_mac[e];
    end
  endtask

  task automatic chk_full(string req);
    logic [15:0] v;
    rd(3'd0, v);
    chk(v[0] == m_full, req, 64'(v[0]), 64'(m_full));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    logic [15:0] v;
    logic [47:0] m;
    logic [7:0] fids [3];
    fids[0] = 8'h00; fids[1] = 8'h01; fids[2] = 8'h23;
    for (int i = 0; i < DEPTH; i++) begin
      m_st[i] = 0; m_mac[i] = 0; m_fid[i] = 0; m_trk[i] = 0; m_pv[i] = 0;
    end
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk(v == 0, "R11 register reset", 64'(v), 0);
    end
    walk(8'h00);

    // R2 layout and read-back
    wr(3'd2, 16'h8A57);
    rd(3'd2, v);
    chk(v == 16'h8A57, "R2 data layout", 64'(v), 64'h8A57);
    set_mac(48'h0102_0304_0506);
    rd_mac(m);
    chk(m == 48'h0102_0304_0506, "R2 mac order", 64'(m), 64'h010203040506);

    // R1 busy visible right after start, then clears
    wr(3'd1, {1'b1, 3'd0, 8'd0, 4'd0});
    rd(3'd1, v);
    chk(v[15] == 1'b1, "R1 busy set", 64'(v[15]), 1);
    wait_idle();
    rd(3'd1, v);
    chk(v[15] == 1'b0, "R1 busy cleared", 64'(v[15]), 0);

    // R4 R3: load, databases sharing low bits
    hw_load(48'h0000_0000_0A00, 8'h23, 4'h7, 1'b1, 8'h05);
    hw_load(48'h0000_0000_0900, 8'h03, 4'hF, 1'b0, 8'h02);
    hw_load(48'h0000_0000_0A00, 8'h23, 4'h8, 1'b0, 8'h09);
    walk(8'h23); walk(8'h03); walk(8'h13);

    // R5 purge existing and absent
    hw_load(48'h0000_0000_0A00, 8'h23, 4'h0, 1'b0, 8'h00);
    hw_load(48'h0000_0000_0B00, 8'h03, 4'h0, 1'b0, 8'h00);
    walk(8'h23); walk(8'h03);

    // R10 writes ignored while busy
    set_mac(48'h1111_2222_3333);
    wr(3'd2, dword(4'h0, 1'b0, 8'h00));
    wr(3'd0, 16'h0000);
    wr(3'd1, {1'b1, 3'd5, 8'd0, 4'h9});
    wr(3'd3, 16'hDEAD);
    wr(3'd2, 16'h0FF3);
    wr(3'd1, {1'b1, 3'd1, 8'd0, 4'h2});
    wr(3'd0, 16'hF000);
    wait_idle();
    rd_mac(m);
    chk(m == 48'h1111_2222_3333, "R10 mac kept", 64'(m), 64'h111122223333);
    rd(3'd2, v);
    chk(v == 16'h0000, "R10 data kept", 64'(v), 0);
    rd(3'd1, v);
    chk(v[14:0] == {3'd5, 8'd0, 4'h9}, "R10 command kept", 64'(v[14:0]),
        64'({3'd5, 8'd0, 4'h9}));
    rd(3'd0, v);
    chk(v[15:12] == 4'h0, "R10 control kept", 64'(v[15:12]), 0);
    walk(8'h03);

    // R7 flush everything
    hw_fm(3'd1, 8'h00, 4'h0, 8'h00);
    walk(8'h03);

    // R8 moves
    hw_load(48'h0000_0000_0100, 8'h01, 4'h7, 1'b0, 8'h03);
    hw_load(48'h0000_0000_0200, 8'h01, 4'hF, 1'b1, 8'h04);
    hw_load(48'h0000_0000_0300, 8'h02, 4'h5, 1'b0, 8'h02);
    hw_fm(3'd2, 8'h00, 4'hF, {2'b00, 3'd5, 3'd1});
    walk(8'h01);
    chk(m_pv[0] == 8'h21, "R8 model move", 64'(m_pv[0]), 64'h21);
    hw_fm(3'd1, 8'h00, 4'hF, {2'b00, 3'd7, 3'd2});
    walk(8'h01);
    hw_fm(3'd6, 8'h02, 4'hF, {2'b00, 3'd7, 3'd1});
    walk(8'h02);
    // R7 other state codes do nothing, per-database scope
    hw_fm(3'd1, 8'h00, 4'h5, 8'h00);
    walk(8'h01);
    hw_fm(3'd5, 8'h01, 4'h0, 8'h00);
    walk(8'h01);

    // R9 fill the table
    hw_fm(3'd1, 8'h00, 4'h0, 8'h00);
    for (int i = 0; i < DEPTH; i++)
      hw_load(48'h0000_0000_1000 + 48'(i), 8'h02, 4'h3, 1'b0, 8'h01);
    chk_full("R9 not yet full");
    hw_load(48'h0000_0000_2000, 8'h02, 4'h3, 1'b0, 8'h01);
    chk_full("R9 full flag set");
    walk(8'h02);
    wr(3'd0, 16'h0001);
    m_full = 0;
    chk_full("R9 full flag cleared");

    // random phase
    hw_fm(3'd1, 8'h00, 4'h0, 8'h00);
    for (int n = 0; n < 80; n++) begin
      int kind;
      logic [7:0] f;
      logic [47:0] mm;
      kind = $urandom_range(0, 9);
      f = fids[$urandom_range(0, 2)];
      mm = 48'h0050_C200_0000 + 48'($urandom_range(0, 6) * 17);
      if (kind < 6)
        hw_load(mm, f, 4'($urandom_range(1, 15)), 1'($urandom_range(0, 1)),
                8'($urandom_range(1, 255)));
      else if (kind == 6)
        hw_load(mm, f, 4'h0, 1'b0, 8'h00);
      else begin
        logic [2:0] ops [4];
        ops[0] = 3'd1; ops[1] = 3'd2; ops[2] = 3'd5; ops[3] = 3'd6;
        hw_fm(ops[$urandom_range(0, 3)], f,
              ($urandom_range(0, 2) == 0) ? 4'h0 : 4'hF,
              {2'b00, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7))});
      end
      if (n % 20 == 19) begin
        walk(8'h00); walk(8'h01); walk(8'h23);
        chk_full("R9 random full flag");
        if (m_full) begin wr(3'd0, 16'h0001); m_full = 0; end
      end
    end

    report();
  end
endmodule